// File: doc/BRIEF.md
# Host Address Window Decoder with Interleave Translation

This block is one programmable address window for a memory expansion endpoint. Software programs a 64-bit window base and a 64-bit window size as pairs of 32-bit words. It then writes a control word that holds the interleave granularity and the interleave way count, and requests arming of the window. The arming request is checked: a legal setting arms the window, and an illegal one raises an error status instead.

Once the window is armed, every host physical address presented on the request port is checked against the window. For an address inside the window, the block removes the interleave-way bits from the offset, which gives the device physical address. The translated address is then compared with the capacity of the backing memory.

A read that falls outside the window, or lands at or beyond the capacity, is flagged with an error. A write under the same conditions is dropped without an error flag. The block holds no memory of its own. Its result is consumed by the memory access path that follows it.

Top module: `mwx_top`

## Requirements
- R1: After reset `committed_o` and `commit_err_o` are 0, `rsp_valid` is 0, and every request reports `rsp_hit`=0 until a legal arming request has been written.
- R2: Register writes take effect only at word-aligned offsets (low two offset bits zero), relative to parameter `DEC0_OFF`: +0x0 base bits 31:0, +0x4 base bits 63:32, +0x8 size bits 31:0, +0xC size bits 63:32, +0x10 control. A write to any other offset, or to a misaligned one, changes neither the status outputs nor the translation.
- R3: The control word carries the granularity IG in bits 3:0, the way count IW in bits 7:4, and the arm request in bit 9. A control write with bit 9 set, IW at most 2 and IG at most 6 sets `committed_o`=1 and `commit_err_o`=0 on the next cycle. The arm request bit itself is not retained.
- R4: A control write with bit 9 set and IW above 2 or IG above 6 sets `commit_err_o`=1 and `committed_o`=0.
- R5: A control write with bit 9 clear stores IG and IW and disarms the window: `committed_o`=0 and `commit_err_o`=0.
- R6: A request hits (`rsp_hit`=1) only when the window is armed, the address is at least the base, and the address minus the base is below the size.
- R7: On a hit, `rsp_dpa` takes the offset's bits below position 8+IG unchanged. Above them it places the offset bits from position 8+IG+IW upward, shifted down by IW. On a miss `rsp_dpa` is 0.
- R8: A read (`req_write`=0) reports `rsp_err`=1 when it misses, or when its device address is at or beyond parameter `CAPACITY`.
- R9: A write never reports `rsp_err`. A write that misses or exceeds capacity is reported only through `rsp_hit`/`rsp_dpa`, so that it can be discarded downstream.
- R10: `rsp_valid` rises exactly one cycle after `req_valid` and carries the result of that request. Back-to-back requests produce back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_off | input | OFF_W | Byte offset of the written word |
| reg_wr_data | input | 32 | Written word |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 64 | Host physical address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | Result strobe |
| rsp_hit | output | 1 | Address inside the armed window |
| rsp_err | output | 1 | Read error response |
| rsp_dpa | output | 64 | Device physical address |
| committed_o | output | 1 | Window armed |
| commit_err_o | output | 1 | Last arming request was rejected |

## Verification
Each register write lands in the register file at the clock edge that follows it. The status outputs, and every request issued from the next cycle on, therefore see the new setting one cycle after the write. A translation result appears one cycle after its request. The bench queues the expected hit, error and device address when it drives the request. A monitor sampling on the falling edge pops the queue whenever `rsp_valid` is high, so a shifted latency shows up as a mismatch or as a count left over in the queue. Status outputs are checked on the falling edge that directly follows the write's clock edge.

// File: rtl/mwx_pkg.sv
package mwx_pkg;
    localparam int WORD_W        = 32;
    localparam int HPA_W         = 64;
    localparam int IG_LSB        = 0;
    localparam int IG_W          = 4;
    localparam int IW_LSB        = 4;
    localparam int IW_W          = 4;
    localparam int ARM_BIT       = 9;
    localparam int GRAN_BASE     = 8;
    localparam int IW_LIMIT      = 2;
    localparam int IG_LIMIT      = 6;

    typedef struct packed {
        logic [HPA_W-1:0] base;
        logic [HPA_W-1:0] size;
        logic [IG_W-1:0]  ig;
        logic [IW_W-1:0]  iw;
        logic             armed;
        logic             arm_err;
    } win_cfg_t;

    typedef struct packed {
        logic             valid;
        logic             hit;
        logic             err;
        logic             wr;
        logic [HPA_W-1:0] dpa;
    } xl_rsp_t;
endpackage

// File: rtl/mwx_regs.sv
module mwx_regs
    import mwx_pkg::*;
#(
    parameter int REG_SPACE_BYTES = 4096,
    parameter int DEC0_OFF        = 'h10,
    localparam int OFF_W          = $clog2(REG_SPACE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [WORD_W-1:0] wr_data,
    output win_cfg_t          cfg
);
    localparam logic [OFF_W-1:0] OFF_BASE_LO = OFF_W'(DEC0_OFF + 'h0);
    localparam logic [OFF_W-1:0] OFF_BASE_HI = OFF_W'(DEC0_OFF + 'h4);
    localparam logic [OFF_W-1:0] OFF_SIZE_LO = OFF_W'(DEC0_OFF + 'h8);
    localparam logic [OFF_W-1:0] OFF_SIZE_HI = OFF_W'(DEC0_OFF + 'hC);
    localparam logic [OFF_W-1:0] OFF_CTRL    = OFF_W'(DEC0_OFF + 'h10);

    win_cfg_t cfg_d, cfg_q;
    logic     aligned;
    logic [IG_W-1:0] new_ig;
    logic [IW_W-1:0] new_iw;
    logic     legal;

    always_comb begin
        cfg_d   = cfg_q;
        aligned = (wr_off[1:0] == 2'b00);
        new_ig  = wr_data[IG_LSB +: IG_W];
        new_iw  = wr_data[IW_LSB +: IW_W];
        legal   = (new_iw <= IW_W'(IW_LIMIT)) && (new_ig <= IG_W'(IG_LIMIT));
        if (wr_en && aligned) begin
            if (wr_off == OFF_BASE_LO) begin
                cfg_d.base[31:0] = wr_data;
            end else if (wr_off == OFF_BASE_HI) begin
                cfg_d.base[63:32] = wr_data;
            end else if (wr_off == OFF_SIZE_LO) begin
                cfg_d.size[31:0] = wr_data;
            end else if (wr_off == OFF_SIZE_HI) begin
                cfg_d.size[63:32] = wr_data;
            end else if (wr_off == OFF_CTRL) begin
                cfg_d.ig = new_ig;
                cfg_d.iw = new_iw;
                if (wr_data[ARM_BIT]) begin
                    cfg_d.armed   = legal;
                    cfg_d.arm_err = !legal;
                end else begin
                    cfg_d.armed   = 1'b0;
                    cfg_d.arm_err = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    // R3
    status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_q.armed && cfg_q.arm_err));

    // R4
    arm_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_off == OFF_CTRL && wr_data[ARM_BIT]) |=> (cfg_q.armed ^ cfg_q.arm_err));

    // R5
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_off == OFF_CTRL && !wr_data[ARM_BIT]) |=> (!cfg_q.armed && !cfg_q.arm_err));
endmodule

// File: rtl/mwx_xlate.sv
module mwx_xlate
    import mwx_pkg::*;
#(
    parameter logic [HPA_W-1:0] CAPACITY = 64'h0010_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  win_cfg_t         cfg,
    input  logic             req_valid,
    input  logic [HPA_W-1:0] req_addr,
    input  logic             req_write,
    output xl_rsp_t          rsp
);
    xl_rsp_t          rsp_d, rsp_q;
    logic [HPA_W-1:0] ofs;
    logic             in_win;
    logic             in_cap;
    logic [6:0]       keep_bits;
    logic [6:0]       upper_src;
    logic [HPA_W-1:0] keep_mask;
    logic [HPA_W-1:0] dpa;

    always_comb begin
        ofs       = req_addr - cfg.base;
        in_win    = cfg.armed && (req_addr >= cfg.base) && (ofs < cfg.size);
        keep_bits = 7'(GRAN_BASE) + {3'b000, cfg.ig};
        upper_src = keep_bits + {3'b000, cfg.iw};
        keep_mask = (64'd1 << keep_bits) - 64'd1;
        dpa       = (ofs & keep_mask) | ((ofs >> upper_src) << keep_bits);
        in_cap    = dpa < CAPACITY;

        rsp_d       = '0;
        rsp_d.valid = req_valid;
        rsp_d.wr    = req_write;
        rsp_d.hit   = req_valid && in_win;
        rsp_d.err   = req_valid && !req_write && !(in_win && in_cap);
        rsp_d.dpa   = (req_valid && in_win) ? dpa : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp = rsp_q;

    // R10
    rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_q.valid);

    // R9
    wr_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_q.valid && rsp_q.wr) |-> !rsp_q.err);

    // R6
    hit_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_q.hit |-> $past(cfg.armed));

    // R8
    rd_miss_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_q.valid && !rsp_q.wr && !rsp_q.hit) |-> rsp_q.err);
endmodule

// File: rtl/mwx_top.sv
module mwx_top
    import mwx_pkg::*;
#(
    parameter int                REG_SPACE_BYTES = 4096,
    parameter int                DEC0_OFF        = 'h10,
    parameter logic [HPA_W-1:0]  CAPACITY        = 64'h0010_0000,
    localparam int               OFF_W           = $clog2(REG_SPACE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [OFF_W-1:0]  reg_wr_off,
    input  logic [31:0]       reg_wr_data,
    input  logic              req_valid,
    input  logic [63:0]       req_addr,
    input  logic              req_write,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_err,
    output logic [63:0]       rsp_dpa,
    output logic              committed_o,
    output logic              commit_err_o
);
    win_cfg_t cfg;
    xl_rsp_t  rsp;

    mwx_regs #(
        .REG_SPACE_BYTES(REG_SPACE_BYTES),
        .DEC0_OFF       (DEC0_OFF)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_off  (reg_wr_off),
        .wr_data (reg_wr_data),
        .cfg     (cfg)
    );

    mwx_xlate #(
        .CAPACITY(CAPACITY)
    ) u_xlate (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_write (req_write),
        .rsp       (rsp)
    );

    assign rsp_valid    = rsp.valid;
    assign rsp_hit      = rsp.hit;
    assign rsp_err      = rsp.err;
    assign rsp_dpa      = rsp.dpa;
    assign committed_o  = cfg.armed;
    assign commit_err_o = cfg.arm_err;

    // R7
    miss_dpa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_dpa == 64'd0));
endmodule

// File: tb/tb_mwx_top.sv
module tb_mwx_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          OFF_W      = 12;
    localparam int          D0         = 'h10;
    localparam logic [63:0] CAP        = 64'h0010_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_en = 1'b0;
    logic [OFF_W-1:0]  reg_wr_off = '0;
    logic [31:0]       reg_wr_data = '0;
    logic              req_valid = 1'b0;
    logic [63:0]       req_addr = '0;
    logic              req_write = 1'b0;
    logic              rsp_valid, rsp_hit, rsp_err;
    logic [63:0]       rsp_dpa;
    logic              committed_o, commit_err_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    mwx_top #(.REG_SPACE_BYTES(4096), .DEC0_OFF(D0), .CAPACITY(CAP)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_off(reg_wr_off),
        .reg_wr_data(reg_wr_data), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_err(rsp_err), .rsp_dpa(rsp_dpa), .committed_o(committed_o),
        .commit_err_o(commit_err_o)
    );

    typedef struct {
        logic        hit;
        logic        err;
        logic [63:0] dpa;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    int   n_chk = 0;
    int   n_err = 0;

    logic [63:0] m_base = '0, m_size = '0;
    int          m_ig = 0, m_iw = 0;
    logic        m_arm = 1'b0, m_aerr = 1'b0;

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pop and compare on the falling edge
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R10 unexpected response", 64'(rsp_valid), 64'd0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(rsp_hit == e.hit, {e.tag, " hit"}, 64'(rsp_hit), 64'(e.hit));
                chk(rsp_err == e.err, {e.tag, " err"}, 64'(rsp_err), 64'(e.err));
                chk(rsp_dpa == e.dpa, {e.tag, " dpa"}, rsp_dpa, e.dpa);
            end
        end
    end

    function automatic logic [63:0] model_dpa(input logic [63:0] o);
        logic [63:0] r;
        r = '0;
        for (int i = 0; i < 64; i++) begin
            if (i < 8 + m_ig) r[i] = o[i];
            else if (i + m_iw < 64) r[i] = o[i + m_iw];
        end
        return r;
    endfunction

    // Register write, called at a falling edge, returns at the next one
    task automatic wreg(input int off, input logic [31:0] data);
        reg_wr_en   = 1'b1;
        reg_wr_off  = OFF_W'(off);
        reg_wr_data = data;
        if (off == D0 + 'h0)       m_base[31:0]  = data;
        else if (off == D0 + 'h4)  m_base[63:32] = data;
        else if (off == D0 + 'h8)  m_size[31:0]  = data;
        else if (off == D0 + 'hC)  m_size[63:32] = data;
        else if (off == D0 + 'h10) begin
            m_ig = int'(data[3:0]);
            m_iw = int'(data[7:4]);
            if (data[9]) begin
                m_arm  = (m_iw <= 2) && (m_ig <= 6);
                m_aerr = !m_arm;
            end else begin
                m_arm  = 1'b0;
                m_aerr = 1'b0;
            end
        end
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // Driver: push expected result and present one request for one cycle
    task automatic send(input logic [63:0] a, input logic wr, input string tag);
        exp_t        e;
        logic [63:0] o;
        logic        win;
        o   = a - m_base;
        win = m_arm && (a >= m_base) && (o < m_size);
        e.hit = win;
        e.dpa = win ? model_dpa(o) : 64'd0;
        e.err = !wr && !(win && (model_dpa(o) < CAP));
        e.tag = tag;
        sbq.push_back(e);
        req_valid = 1'b1;
        req_addr  = a;
        req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic chk_status(input string tag);
        chk(committed_o == m_arm, {tag, " committed"}, 64'(committed_o), 64'(m_arm));
        chk(commit_err_o == m_aerr, {tag, " commit_err"}, 64'(commit_err_o), 64'(m_aerr));
    endtask

    logic done = 1'b0;

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_status("R1 reset");
        chk(rsp_valid == 1'b0, "R1 rsp_valid idle", 64'(rsp_valid), 64'd0);
        send(64'h0, 1'b0, "R1 unarmed read");
        send(64'h1234, 1'b1, "R1 unarmed write");

        // Program window, IG=0 IW=1, arm
        wreg(D0 + 'h0, 32'h0);
        wreg(D0 + 'h4, 32'h1);
        wreg(D0 + 'h8, 32'h0004_0000);
        wreg(D0 + 'hC, 32'h0);
        send(64'h1_0000_0100, 1'b0, "R1 programmed but unarmed");
        wreg(D0 + 'h10, 32'h0000_0210);
        chk_status("R3 legal arm");
        // R7 R10 back-to-back
        send(64'h1_0000_0123, 1'b0, "R7 iw1 low");
        send(64'h1_0000_3456, 1'b0, "R7 iw1 upper");
        send(64'h1_0003_FFFF, 1'b1, "R6 last byte");
        send(64'h1_0004_0000, 1'b0, "R6 offset equals size");
        send(64'h0_FFFF_FFFF, 1'b0, "R8 below base read");
        send(64'h0_FFFF_FFFF, 1'b1, "R9 below base write");

        // R2 ignored writes: unmapped and misaligned
        wreg('h200, 32'h0000_0000);
        wreg(D0 + 'h1, 32'hFFFF_FFFF);
        wreg(D0 + 'h11, 32'h0000_0000);
        chk_status("R2 ignored writes");
        send(64'h1_0000_3456, 1'b0, "R2 translation unchanged");

        // Capacity: IW=0, large window
        wreg(D0 + 'h8, 32'h0040_0000);
        wreg(D0 + 'h10, 32'h0000_0200);
        chk_status("R3 rearm iw0");
        send(64'h1_000F_FFFF, 1'b0, "R8 last in capacity");
        send(64'h1_0010_0000, 1'b0, "R8 at capacity read");
        send(64'h1_0010_0000, 1'b1, "R9 at capacity write");

        // IG=6 IW=2
        wreg(D0 + 'h10, 32'h0000_0226);
        chk_status("R3 arm ig6 iw2");
        send(64'h1_0001_2345, 1'b0, "R7 ig6 iw2 a");
        send(64'h1_003A_BCDE, 1'b0, "R7 ig6 iw2 b");
        send(64'h1_0000_4000, 1'b1, "R7 ig6 iw2 c");

        // R4 illegal arm
        wreg(D0 + 'h10, 32'h0000_0230);
        chk_status("R4 iw3 rejected");
        send(64'h1_0000_0010, 1'b0, "R4 miss after reject");
        wreg(D0 + 'h10, 32'h0000_0207);
        chk_status("R4 ig7 rejected");

        // R5 disarm
        wreg(D0 + 'h10, 32'h0000_0211);
        chk_status("R5 rearm");
        send(64'h1_0000_0888, 1'b0, "R5 hit before disarm");
        wreg(D0 + 'h10, 32'h0000_0011);
        chk_status("R5 disarm");
        send(64'h1_0000_0888, 1'b0, "R5 miss after disarm");

        repeat (3) @(negedge clk);
        chk(sbq.size() == 0, "R10 all responses seen", 64'(sbq.size()), 64'd0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule